// File: doc/BRIEF.md
# Board Control and Status Register with Watchdog and Bus-Error Timer

This block is a byte-wide control and status register on a simple processor bus. It holds the green front-panel LED enable, the enables for two timers and a set of sticky event flags. Software reads the flags to find out why the board last reset, and why a bus cycle ended in error.

The block has two timers. The watchdog can only be switched on once per reset. Once on, software must restart it by writing the trigger bit. If no restart comes within the timeout, the watchdog sets its flag and raises a reset request. The on-board bus-error timer runs while its enable bit is set and an on-board I/O cycle is active. The cycle-active input includes the wait for bus arbitration. If the cycle lasts too long, the timer raises the bus-error output.

Both timeouts are derived from the clock frequency through millisecond and microsecond prescalers. The block has two resets. The power-on/push-button reset clears everything. The system reset, which is what the watchdog request eventually drives, clears everything except the watchdog-expired flag.

Top module: `board_ctrl_reg`

## Requirements
- R1: After a power-on reset, the register reads 0x00 and the LED, bus-error and reset-request outputs are all 0.
- R2: Writing 1 to bit 4 (watchdog enable) sets it. It stays set until a reset, and writing 0 to it has no effect.
- R3: While enabled, the watchdog raises its reset request exactly WDOG_MS × CLK_KHZ clock cycles after the last write that set bit 3 (trigger) or first set the enable. A trigger write restarts this count. Bit 3 always reads 0, and a disabled watchdog never requests a reset.
- R4: On expiry, bit 7 is set and wdog_rst_req goes high and stays high until a reset. The system reset clears the request and every bit except bit 7.
- R5: Writes never change bit 7. Only an expiry sets it, and only the power-on reset clears it.
- R6: With bit 2 set, bus_err rises on the BERR_US × (CLK_KHZ/1000)-th consecutive clock edge at which io_cycle is high. It falls at the first edge at which io_cycle is low. With bit 2 clear, bus_err stays 0.
- R7: Bus-error timer expiry sets bit 5, and a high vme_berr_to input sets bit 6.
- R8: A high acfail input at a clock edge sets bit 1.
- R9: Writing 0 to bit 6, 5 or 1 clears that flag, and writing 1 leaves it unchanged. If the flag's event arrives in the same cycle as the clearing write, the event wins.
- R10: Bits 2 and 0 hold the last written value, and led_green follows bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on/push-button reset, active low, clears all state |
| sys_rst_n | input | 1 | System reset, active low, clears all state except bit 7 |
| cs | input | 1 | Register select |
| we | input | 1 | Write strobe (read when low with cs high) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| io_cycle | input | 1 | On-board I/O cycle or arbitration wait in progress |
| bus_err | output | 1 | Bus-error timer timeout |
| vme_berr_to | input | 1 | Timeout report from the external bus-error timer |
| acfail | input | 1 | Power-fail input |
| wdog_rst_req | output | 1 | Watchdog reset request |
| led_green | output | 1 | Green LED enable |

## Verification
The bench builds the block with CLK_KHZ = 4000, WDOG_MS = 4 and BERR_US = 8. This gives a watchdog timeout of 16,000 cycles and a bus-error timeout of 32 cycles, so the bench can reach the exact expiry edge of both timers, a mid-period restart and a wait past a missed deadline. With a 4-cycle microsecond prescaler and a 4000-cycle millisecond prescaler, the test also covers the prescaler wrap-around inside each timeout count.

// File: rtl/board_ctrl_reg.sv
module board_ctrl_reg #(
  parameter int CLK_KHZ = 33000,
  parameter int WDOG_MS = 512,
  parameter int BERR_US = 8
) (
  input  logic       clk,
  input  logic       por_rst_n,
  input  logic       sys_rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       io_cycle,
  output logic       bus_err,
  input  logic       vme_berr_to,
  input  logic       acfail,
  output logic       wdog_rst_req,
  output logic       led_green
);
  localparam int MS_DIV = CLK_KHZ;
  localparam int US_DIV = (CLK_KHZ / 1000 > 0) ? CLK_KHZ / 1000 : 1;
  localparam int MSW = $clog2(MS_DIV + 1);
  localparam int USW = $clog2(US_DIV + 1);
  localparam int WCW = $clog2(WDOG_MS + 1);
  localparam int BCW = $clog2(BERR_US + 1);

  logic rst_all_n, wr;
  logic wd_en, wd_flag, be_en, be_flag, vme_flag, acf_flag, led;
  logic [MSW-1:0] wd_pre;
  logic [WCW-1:0] wd_cnt;
  logic [USW-1:0] be_pre;
  logic [BCW-1:0] be_cnt;
  logic wd_kick, wd_tick, wd_expire, be_run, be_tick, be_expire;

  assign rst_all_n = por_rst_n & sys_rst_n;
  assign wr        = cs & we;

  assign wd_kick   = wr && (wdata[3] || (wdata[4] && !wd_en));
  assign wd_tick   = wd_pre == MSW'(MS_DIV - 1);
  assign wd_expire = wd_en && !wdog_rst_req && !wd_kick && wd_tick && wd_cnt == WCW'(WDOG_MS - 1);

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      wd_en <= 1'b0; wd_pre <= '0; wd_cnt <= '0; wdog_rst_req <= 1'b0;
    end else begin
      if (wr && wdata[4]) wd_en <= 1'b1;
      if (wd_kick) begin
        wd_pre <= '0; wd_cnt <= '0;
      end else if (wd_en && !wdog_rst_req) begin
        if (wd_tick) begin
          wd_pre <= '0; wd_cnt <= wd_cnt + 1'b1;
        end else wd_pre <= wd_pre + 1'b1;
      end
      if (wd_expire) wdog_rst_req <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) wd_flag <= 1'b0;
    else if (wd_expire) wd_flag <= 1'b1;
  end

  assign be_run    = be_en && io_cycle;
  assign be_tick   = be_pre == USW'(US_DIV - 1);
  assign be_expire = be_run && !bus_err && be_tick && be_cnt == BCW'(BERR_US - 1);

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      be_pre <= '0; be_cnt <= '0; bus_err <= 1'b0;
    end else if (!be_run) begin
      be_pre <= '0; be_cnt <= '0; bus_err <= 1'b0;
    end else if (be_expire) begin
      bus_err <= 1'b1;
    end else if (!bus_err) begin
      if (be_tick) begin
        be_pre <= '0; be_cnt <= be_cnt + 1'b1;
      end else be_pre <= be_pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n) begin
      be_en <= 1'b0; led <= 1'b0; be_flag <= 1'b0; vme_flag <= 1'b0; acf_flag <= 1'b0;
    end else begin
      if (wr) begin
        be_en <= wdata[2];
        led   <= wdata[0];
      end
      if (vme_berr_to) vme_flag <= 1'b1;
      else if (wr && !wdata[6]) vme_flag <= 1'b0;
      if (be_expire) be_flag <= 1'b1;
      else if (wr && !wdata[5]) be_flag <= 1'b0;
      if (acfail) acf_flag <= 1'b1;
      else if (wr && !wdata[1]) acf_flag <= 1'b0;
    end
  end

  assign led_green = led;
  assign rdata = (cs && !we) ? {wd_flag, vme_flag, be_flag, wd_en, 1'b0, be_en, acf_flag, led} : 8'h00;

  p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_all_n) wd_en |=> wd_en);
  p_req_flag_r4: assert property (@(posedge clk) disable iff (!rst_all_n) wdog_rst_req |-> wd_flag);
  p_bit7_wr_r5: assert property (@(posedge clk) disable iff (!rst_all_n)
    (wr && !wd_expire) |=> wd_flag == $past(wd_flag));
  p_berr_io_r6: assert property (@(posedge clk) disable iff (!rst_all_n) bus_err |-> $past(io_cycle));
  p_berr_flag_r7: assert property (@(posedge clk) disable iff (!rst_all_n) $rose(bus_err) |-> be_flag);
  p_vme_flag_r7: assert property (@(posedge clk) disable iff (!rst_all_n) vme_berr_to |=> vme_flag);
  p_acf_latch_r8: assert property (@(posedge clk) disable iff (!rst_all_n) acfail |=> acf_flag);
endmodule

// File: tb/test_board_ctrl_reg.sv
module test_board_ctrl_reg;
  localparam int CLK_KHZ = 4000;
  localparam int WDOG_MS = 4;
  localparam int BERR_US = 8;
  localparam int WD_CYC  = WDOG_MS * CLK_KHZ;
  localparam int BE_CYC  = BERR_US * (CLK_KHZ / 1000);

  logic clk = 1'b0, por_rst_n = 1'b0, sys_rst_n = 1'b1, cs = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic io_cycle = 1'b0, vme_berr_to = 1'b0, acfail = 1'b0;
  logic bus_err, wdog_rst_req, led_green;
  int checks = 0, errors = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  board_ctrl_reg #(.CLK_KHZ(CLK_KHZ), .WDOG_MS(WDOG_MS), .BERR_US(BERR_US)) i_board_ctrl_reg (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n), .cs(cs), .we(we),
    .wdata(wdata), .rdata(rdata), .io_cycle(io_cycle), .bus_err(bus_err),
    .vme_berr_to(vme_berr_to), .acfail(acfail), .wdog_rst_req(wdog_rst_req),
    .led_green(led_green));

  // {wdata, acfail, vme_berr_to, expected read}
  localparam logic [17:0] VEC [11] = '{
    {8'h01, 1'b0, 1'b0, 8'h01},
    {8'h05, 1'b0, 1'b0, 8'h05},
    {8'h8D, 1'b0, 1'b0, 8'h05},
    {8'h04, 1'b1, 1'b0, 8'h06},
    {8'h06, 1'b0, 1'b0, 8'h06},
    {8'h04, 1'b0, 1'b0, 8'h04},
    {8'h05, 1'b0, 1'b1, 8'h45},
    {8'h47, 1'b0, 1'b0, 8'h45},
    {8'h05, 1'b0, 1'b0, 8'h05},
    {8'h15, 1'b0, 1'b0, 8'h15},
    {8'h05, 1'b0, 1'b0, 8'h15}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d, input logic a, input logic v);
    cs = 1'b1; we = 1'b1; wdata = d; acfail = a; vme_berr_to = v;
    @(negedge clk);
    cs = 1'b0; we = 1'b0; acfail = 1'b0; vme_berr_to = 1'b0;
  endtask

  task automatic rd_reg(output logic [7:0] d);
    cs = 1'b1; we = 1'b0;
    #1 d = rdata;
    cs = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1;
    @(negedge clk);
    rd_reg(rv); check("R1 reset read", rv, 8'h00);
    check("R1 reset outputs", {5'b0, led_green, bus_err, wdog_rst_req}, 8'h00);

    for (int i = 0; i < 11; i++) begin
      wr_reg(VEC[i][17:10], VEC[i][9], VEC[i][8]);
      rd_reg(rv);
      check($sformatf("R2/R5/R7/R8/R9 vector %0d", i), rv, VEC[i][7:0]);
      check($sformatf("R10 led vector %0d", i), {7'b0, led_green}, {7'b0, VEC[i][0]});
    end

    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    rd_reg(rv); check("R4 sys reset clears", rv, 8'h00);

    wr_reg(8'h08, 1'b0, 1'b0);
    repeat (WD_CYC + 10) @(negedge clk);
    check("R3 disabled no request", {7'b0, wdog_rst_req}, 8'h00);

    wr_reg(8'h10, 1'b0, 1'b0);
    repeat (WD_CYC / 2) @(negedge clk);
    wr_reg(8'h18, 1'b0, 1'b0);
    rd_reg(rv); check("R3 trigger reads 0", rv, 8'h10);
    repeat (WD_CYC - 2) @(negedge clk);
    check("R3 before expiry", {7'b0, wdog_rst_req}, 8'h00);
    rd_reg(rv); check("R3 flag before expiry", rv, 8'h10);
    repeat (2) @(negedge clk);
    check("R4 request at expiry", {7'b0, wdog_rst_req}, 8'h01);
    rd_reg(rv); check("R4 flag at expiry", rv, 8'h90);

    sys_rst_n = 1'b0; @(negedge clk); sys_rst_n = 1'b1; @(negedge clk);
    check("R4 request cleared", {7'b0, wdog_rst_req}, 8'h00);
    rd_reg(rv); check("R4 flag survives sys reset", rv, 8'h80);
    wr_reg(8'h00, 1'b0, 1'b0);
    rd_reg(rv); check("R5 write 0 to bit 7 ignored", rv, 8'h80);

    wr_reg(8'h04, 1'b0, 1'b0);
    io_cycle = 1'b1;
    repeat (BE_CYC - 1) @(negedge clk);
    check("R6 before timeout", {7'b0, bus_err}, 8'h00);
    @(negedge clk);
    check("R6 at timeout", {7'b0, bus_err}, 8'h01);
    rd_reg(rv); check("R7 on-board flag", rv, 8'hA4);
    io_cycle = 1'b0;
    @(negedge clk);
    check("R6 drops with io_cycle", {7'b0, bus_err}, 8'h00);
    wr_reg(8'h00, 1'b0, 1'b0);
    rd_reg(rv); check("R9 clear bit 5", rv, 8'h80);
    io_cycle = 1'b1;
    repeat (BE_CYC + 4) @(negedge clk);
    check("R6 disabled no error", {7'b0, bus_err}, 8'h00);
    rd_reg(rv); check("R6 disabled no flag", rv, 8'h80);
    io_cycle = 1'b0;

    por_rst_n = 1'b0; @(negedge clk); por_rst_n = 1'b1; @(negedge clk);
    rd_reg(rv); check("R1 power-on clears bit 7", rv, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule